// File: doc/BRIEF.md
# Address-Mapped Mesh Router Tile

This block is a single node of a two-dimensional mesh that moves load and store requests across one flat physical address space. Every tile of a 16 by 16 grid owns a contiguous 128 KB window of that space. The node learns where a request must go only from its address: bits above the 17-bit scratchpad offset name the owning tile, split into a column (X) and a row (Y) coordinate.

The node has five input ports (the local core and the four neighbour links) and five output ports (the local scratchpad and the four neighbour links). Each input has a one-entry holding register. A request sitting in that register is steered by dimension-order routing: it first travels along X until the column matches, then along Y, and it is handed to the local scratchpad port once both coordinates match. Requests that target this tile never leave it. When several held requests want the same output in one cycle, a per-output round-robin arbiter picks one. The others stay in their registers and drop their upstream ready until they win. A request advances one tile per clock, so an uncontended trip costs one cycle per tile crossed.

Top module: `mesh_router_node`

## Requirements
- R1: A flit is 73 bits: bit [72] write flag, bits [71:40] the 32-bit address, bits [39:8] write data, bits [7:0] source tile. The owning tile's column X is address bits [20:17] and its row Y is address bits [24:21]. Address bits [16:0] and [31:25] have no effect on the route taken.
- R2: Port numbering is 0 local, 1 north, 2 south, 3 east, 4 west. If the target column is greater than the node's own column, the flit leaves on port 3 (east). If it is smaller, the flit leaves on port 4 (west). This holds regardless of the row.
- R3: If the target column equals the node's own column, a greater target row sends the flit out on port 1 (north) and a smaller target row sends it out on port 2 (south).
- R4: A flit whose column and row both equal the node's own coordinates leaves only on port 0 (local scratchpad), including flits injected by the local core.
- R5: A flit accepted at a clock edge (input valid and ready both high) is presented unchanged on its output in the cycle right after that edge, provided no other held flit wins that output.
- R6: When several held flits request the same output, the grant goes to the first requester after the input index last granted on that output, searching in cyclic order 0,1,2,3,4. After reset, index 0 has first priority. The arbiter's position moves only when the granted flit is taken (output ready high).
- R7: An input's ready is low exactly when its holding register is occupied and the held flit is not leaving in this cycle. A held flit is not overwritten.
- R8: Every accepted flit leaves the node exactly once: after a drain, the number of flits delivered equals the number accepted.
- R9: While reset is low, no output is valid and every input is ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 5 | Per input port: a flit is offered |
| in_flit | input | 5x73 | Per input port: offered flit |
| in_ready | output | 5 | Per input port: the node takes the offered flit at this edge |
| out_valid | output | 5 | Per output port: a flit is presented |
| out_flit | output | 5x73 | Per output port: presented flit |
| out_ready | input | 5 | Per output port: the downstream side takes the flit at this edge |

## Verification
The checker assumes that each upstream sender keeps a flit valid and unchanged while that input's ready is low, and that downstream ready may toggle freely. The stimulus obeys this: it remembers every input that was refused and re-offers the identical flit on it before drawing anything new. It also biases target coordinates toward the node's own column and row, so every routing branch and the local case occur often. Load phases push all five inputs at once against random output stalls, so ties, held flits and arbiter rotation are exercised under a reference model that is compared on every cycle.

// File: rtl/mesh_node_pkg.sv
// Shared constants and flit type for the mesh router tile.
// Assumes a 16x16 grid of 128 KB tiles in a 32-bit physical space.
package mesh_node_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int OFFS_W  = 17;               // scratchpad offset bits per tile
    localparam int COORD_W = 4;                // bits per grid coordinate
    localparam int SRC_W   = 2 * COORD_W;      // tile index width
    localparam int NPORT   = 5;
    localparam int PORT_W  = $clog2(NPORT);

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SRC_W-1:0]  src;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);

    typedef enum logic [PORT_W-1:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_SOUTH = 3'd2,
        PORT_EAST  = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;
endpackage

// File: rtl/mesh_route_sel.sv
// Dimension-order route decision for one held flit.
// Assumes X grows toward east and Y grows toward north.
module mesh_route_sel
    import mesh_node_pkg::*;
#(
    parameter int MY_X = 0,
    parameter int MY_Y = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output port_e             port
);
    localparam logic [COORD_W-1:0] OWN_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] OWN_Y = COORD_W'(MY_Y);

    logic [COORD_W-1:0] tgt_x;
    logic [COORD_W-1:0] tgt_y;

    assign tgt_x = addr[OFFS_W +: COORD_W];
    assign tgt_y = addr[OFFS_W + COORD_W +: COORD_W];

    // Resolve column first, then row, then deliver locally.
    always_comb begin
        if (tgt_x > OWN_X)      port = PORT_EAST;
        else if (tgt_x < OWN_X) port = PORT_WEST;
        else if (tgt_y > OWN_Y) port = PORT_NORTH;
        else if (tgt_y < OWN_Y) port = PORT_SOUTH;
        else                    port = PORT_LOCAL;
    end
endmodule

// File: rtl/mesh_in_slot.sv
// One-entry holding register on an input link.
// Assumes the sender keeps its flit stable while ready is low.
module mesh_in_slot
    import mesh_node_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FLIT_W-1:0] in_flit,
    input  logic              take,
    output logic              in_ready,
    output logic              held_valid,
    output logic [FLIT_W-1:0] held_flit
);
    assign in_ready = !held_valid || take;

    // Occupancy: fill on accept, empty when taken without refill.
    always_ff @(posedge clk) begin
        if (!rst_n)                    held_valid <= 1'b0;
        else if (in_valid && in_ready) held_valid <= 1'b1;
        else if (take)                 held_valid <= 1'b0;
    end

    // Payload capture on accept.
    always_ff @(posedge clk) begin
        if (in_valid && in_ready) held_flit <= in_flit;
    end
endmodule

// File: rtl/mesh_rr_arb.sv
// Round-robin arbiter for one output port.
// Assumes requests are stable within a cycle; position moves only on a taken grant.
module mesh_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         taken,
    output logic [N-1:0] gnt
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] win_idx;
    logic             found;

    // Search cyclically from the slot after the last winner.
    always_comb begin
        int idx;
        gnt     = '0;
        found   = 1'b0;
        win_idx = '0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last_q) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
                win_idx  = IDX_W'(idx);
            end
        end
    end

    // Remember the last winner whose flit was taken.
    always_ff @(posedge clk) begin
        if (!rst_n)              last_q <= IDX_W'(N - 1);
        else if (found && taken) last_q <= win_idx;
    end
endmodule

// File: rtl/mesh_router_node.sv
// Mesh router tile: five held inputs, dimension-order steering and
// per-output round-robin arbitration. One register stage per tile.
// Assumes upstream senders hold a refused flit until it is accepted.
module mesh_router_node
    import mesh_node_pkg::*;
#(
    parameter int MY_X = 0,
    parameter int MY_Y = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             in_valid,
    input  logic [NPORT-1:0][FLIT_W-1:0] in_flit,
    output logic [NPORT-1:0]             in_ready,
    output logic [NPORT-1:0]             out_valid,
    output logic [NPORT-1:0][FLIT_W-1:0] out_flit,
    input  logic [NPORT-1:0]             out_ready
);
    logic [NPORT-1:0]             held_v;
    logic [NPORT-1:0][FLIT_W-1:0] held_f;
    port_e                        dest [NPORT];
    logic [NPORT-1:0]             take;
    logic [NPORT-1:0][NPORT-1:0]  req;   // [output][input]
    logic [NPORT-1:0][NPORT-1:0]  gnt;   // [output][input]

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        flit_t held_s;
        assign held_s = flit_t'(held_f[i]);

        mesh_in_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[i]),
            .in_flit   (in_flit[i]),
            .take      (take[i]),
            .in_ready  (in_ready[i]),
            .held_valid(held_v[i]),
            .held_flit (held_f[i])
        );

        mesh_route_sel #(.MY_X(MY_X), .MY_Y(MY_Y)) u_route (
            .addr(held_s.addr),
            .port(dest[i])
        );
    end

    // Request matrix: held flit i wants output o.
    always_comb begin
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NPORT; i++)
                req[o][i] = held_v[i] && (int'(dest[i]) == o);
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        mesh_rr_arb #(.N(NPORT)) u_arb (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req[o]),
            .taken(out_ready[o]),
            .gnt  (gnt[o])
        );
    end

    // Output crossbar: select the granted held flit per output.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            out_valid[o] = |gnt[o];
            out_flit[o]  = '0;
            for (int i = 0; i < NPORT; i++)
                if (gnt[o][i]) out_flit[o] = held_f[i];
        end
    end

    // An input slot empties when its granted output is ready.
    always_comb begin
        take = '0;
        for (int i = 0; i < NPORT; i++)
            for (int o = 0; o < NPORT; o++)
                if (gnt[o][i] && out_ready[o]) take[i] = 1'b1;
    end
endmodule

// File: rtl/mesh_router_node_chk.sv
// Protocol and routing checker for mesh_router_node, bound to every instance.
// Assumes senders keep refused flits valid and stable.
module mesh_router_node_chk
    import mesh_node_pkg::*;
#(
    parameter int MY_X = 0,
    parameter int MY_Y = 0
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NPORT-1:0]             in_valid,
    input logic [NPORT-1:0]             in_ready,
    input logic [NPORT-1:0]             out_valid,
    input logic [NPORT-1:0][FLIT_W-1:0] out_flit,
    input logic [NPORT-1:0]             out_ready
);
    // Expected exit port from signed coordinate distances.
    function automatic int exit_of(logic [FLIT_W-1:0] f);
        flit_t fs;
        int    dx;
        int    dy;
        fs = flit_t'(f);
        dx = int'(fs.addr[OFFS_W +: COORD_W]) - MY_X;
        dy = int'(fs.addr[OFFS_W + COORD_W +: COORD_W]) - MY_Y;
        if (dx != 0) return (dx > 0) ? 3 : 4;
        if (dy != 0) return (dy > 0) ? 1 : 2;
        return 0;
    endfunction

    // R9: reset leaves the node idle and fully ready.
    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0) && (in_ready == '1));

    for (genvar o = 0; o < NPORT; o++) begin : g_o
        // R2, R3, R4: a presented flit sits on the port its address selects.
        assert_route_matches_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> (exit_of(out_flit[o]) == o));

        // R5: an output can only carry a flit accepted earlier or still waiting.
        assert_output_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> ($past(|(in_valid & in_ready)) || $past(out_valid[o])));
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_i
        // R7: a refusing input was either just filled or already refusing.
        assert_full_slot_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_ready[i] |-> ($past(in_valid[i] && in_ready[i]) || $past(!in_ready[i])));
    end

    // Keeps the output handshake in the checked interface.
    logic unused_ok;
    assign unused_ok = ^out_ready;
endmodule

bind mesh_router_node mesh_router_node_chk #(.MY_X(MY_X), .MY_Y(MY_Y)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_flit (out_flit),
    .out_ready(out_ready)
);

// File: tb/mesh_router_node_tb_top.sv
// Self-checking bench: behavioural reference model compared every cycle.
module mesh_router_node_tb_top;
    import mesh_node_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NODE_X     = 6;
    localparam int NODE_Y     = 9;
    localparam int NP         = 5;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NP-1:0]             in_valid = '0;
    logic [NP-1:0][FLIT_W-1:0] in_flit = '0;
    logic [NP-1:0]             in_ready;
    logic [NP-1:0]             out_valid;
    logic [NP-1:0][FLIT_W-1:0] out_flit;
    logic [NP-1:0]             out_ready = '0;

    mesh_router_node #(.MY_X(NODE_X), .MY_Y(NODE_Y)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_flit  (in_flit),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_flit (out_flit),
        .out_ready(out_ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int failures = 0;

    // Reference state
    bit               m_v   [NP];
    logic [FLIT_W-1:0] m_f  [NP];
    int               m_last[NP];
    bit               hold  [NP];
    int               accepted = 0;
    int               delivered = 0;

    // Exit port from address fields (R1..R4), own arithmetic.
    function automatic int route_of(logic [FLIT_W-1:0] f);
        logic [31:0] a;
        int x;
        int y;
        a = f[71:40];
        x = int'((a >> 17) & 32'hF);
        y = int'((a >> 21) & 32'hF);
        if (x > NODE_X) return 3;
        if (x < NODE_X) return 4;
        if (y > NODE_Y) return 1;
        if (y < NODE_Y) return 2;
        return 0;
    endfunction

    function automatic logic [FLIT_W-1:0] make_flit();
        logic [31:0] a;
        int x;
        int y;
        x = ($urandom % 3 == 0) ? NODE_X : int'($urandom % 16);
        y = ($urandom % 3 == 0) ? NODE_Y : int'($urandom % 16);
        a = ($urandom & 32'hFE00_0000) | (32'(y) << 21) | (32'(x) << 17) | ($urandom & 32'h0001_FFFF);
        return {1'($urandom), a, 32'($urandom), 8'($urandom)};
    endfunction

    task automatic check(bit ok, string tag, logic [FLIT_W-1:0] act, logic [FLIT_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: compare against the model, then advance the model.
    task automatic step_and_compare();
        int  g    [NP];
        int  ncand[NP];
        bit  fire [NP];
        bit  exp_rdy[NP];
        int  k;
        for (int o = 0; o < NP; o++) begin
            g[o] = -1;
            ncand[o] = 0;
            for (int i = 0; i < NP; i++)
                if (m_v[i] && route_of(m_f[i]) == o) ncand[o]++;
            for (int s = 1; s <= NP; s++) begin
                k = (m_last[o] + s) % NP;
                if (g[o] < 0 && m_v[k] && route_of(m_f[k]) == o) g[o] = k;
            end
        end
        for (int i = 0; i < NP; i++) begin
            fire[i] = 1'b0;
            if (m_v[i]) begin
                k = route_of(m_f[i]);
                fire[i] = (g[k] == i) && out_ready[k];
            end
            exp_rdy[i] = !m_v[i] || fire[i];
        end
        for (int o = 0; o < NP; o++) begin
            // R2 east/west, R3 north/south, R4 local
            if (o == 0)      check(out_valid[o] == (g[o] >= 0), "R4 out_valid local", FLIT_W'(out_valid[o]), FLIT_W'(g[o] >= 0));
            else if (o <= 2) check(out_valid[o] == (g[o] >= 0), "R3 out_valid north/south", FLIT_W'(out_valid[o]), FLIT_W'(g[o] >= 0));
            else             check(out_valid[o] == (g[o] >= 0), "R2 out_valid east/west", FLIT_W'(out_valid[o]), FLIT_W'(g[o] >= 0));
            if (g[o] >= 0) begin
                if (ncand[o] > 1) check(out_flit[o] == m_f[g[o]], "R6 round-robin winner", out_flit[o], m_f[g[o]]);
                else              check(out_flit[o] == m_f[g[o]], "R5 one-cycle flit", out_flit[o], m_f[g[o]]);
            end
        end
        for (int i = 0; i < NP; i++)
            check(in_ready[i] == exp_rdy[i], "R7 in_ready", FLIT_W'(in_ready[i]), FLIT_W'(exp_rdy[i]));
        for (int i = 0; i < NP; i++) begin
            if (fire[i]) begin
                m_last[route_of(m_f[i])] = i;
                delivered++;
            end
            if (in_valid[i] && exp_rdy[i]) begin
                m_v[i] = 1'b1;
                m_f[i] = in_flit[i];
                accepted++;
            end else if (fire[i]) begin
                m_v[i] = 1'b0;
            end
            hold[i] = in_valid[i] && !exp_rdy[i];
        end
    endtask

    task automatic run_phase(int cycles, int load, int rdy_pct);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            for (int i = 0; i < NP; i++) begin
                if (!hold[i]) begin
                    in_valid[i] = (int'($urandom % 100) < load);
                    if (in_valid[i]) in_flit[i] = make_flit();
                end
            end
            for (int o = 0; o < NP; o++) out_ready[o] = (int'($urandom % 100) < rdy_pct);
            #1;
            step_and_compare();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) begin
            m_v[i] = 1'b0;
            m_f[i] = '0;
            m_last[i] = NP - 1;
            hold[i] = 1'b0;
        end
        repeat (2) @(posedge clk);
        @(negedge clk);
        out_ready = '1;
        #1;
        // R9: idle and ready while in reset
        check(out_valid == '0, "R9 out_valid in reset", FLIT_W'(out_valid), '0);
        check(in_ready == '1, "R9 in_ready in reset", FLIT_W'(in_ready), FLIT_W'(5'h1F));
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == '0, "R9 out_valid after release", FLIT_W'(out_valid), '0);

        run_phase(1500, 40, 90);   // light load, mostly uncontended (R1, R5)
        run_phase(1500, 100, 50);  // saturation with stalls (R6, R7)
        run_phase(1000, 70, 75);

        // Drain: only held flits stay offered, all outputs ready.
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            for (int i = 0; i < NP; i++) if (!hold[i]) in_valid[i] = 1'b0;
            out_ready = '1;
            #1;
            step_and_compare();
        end
        // R8: everything accepted was delivered exactly once
        check(accepted == delivered, "R8 accepted vs delivered", FLIT_W'(delivered), FLIT_W'(accepted));
        check(out_valid == '0, "R8 drained outputs idle", FLIT_W'(out_valid), '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule